// File: doc/BRIEF.md
# Dual-Bank Alternate Coefficient Updater

This block carries out the coefficient step of a fast affine-projection adaptive filter. A single scalar, the last element of the normalised error vector, is scaled by the run-time relaxation factor once per iteration. That step is then applied to every alternate coefficient. Each coefficient gains the step times the matching sample of the excitation window, where the window is delayed by N-1 samples.

The L coefficients are interleaved over two external single-cycle RAM banks. Each bank has its own read-multiply-add-write pipeline, and both pipelines sweep at the same time, so the pass takes about L/2 cycles instead of L. Samples come from the circular excitation store through two read ports, one per pipeline. The store's base pointer is supplied with the start pulse. When the done pulse appears, the iteration is complete and the filter can take the next input sample.

Arithmetic is two's-complement fixed point with FRAC_W fraction bits. With the defaults (16 bits, 14 fraction bits), the relaxation factor covers the range 0 to just under 2.

Top module: `coef_dual_updater`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, done_o and all read and write enables are low.
- R2: On an accepted start, step = sat((mu_i*eps_i) >>> FRAC_W) is captured. It is used for the whole pass, even if mu_i or eps_i change during the pass.
- R3: Every live coefficient i is replaced by sat(w_i + ((step*x_i) >>> FRAC_W)). The result saturates to the signed DATA_W range.
- R4: Coefficient 2m lives in bank 0 at address m, and coefficient 2m+1 lives in bank 1 at address m.
- R5: Coefficient i uses the excitation word at address (base + PROJ_N-1 + i) mod 2^UX_AW. In the first cycle after start is sampled, port 0 addresses (base+PROJ_N-1) and port 1 addresses (base+PROJ_N).
- R6: When L is odd, bank 1 address (L-1)/2 is never read or written.
- R7: Both banks run concurrently, each handling one coefficient per cycle in ascending address order. Read data is taken one cycle after the address. The write of an element comes two cycles after its read enable, so the first writes of both banks appear together two edges after the start edge.
- R8: busy_o rises on the edge that samples start_i. done_o is a single-cycle pulse raised exactly ceil(L/2)+2 edges after that edge, and busy_o falls on the same edge.
- R9: A start_i pulse while busy_o is high is ignored: it causes no second pass and no second done.
- R10: Saturation reaches both rails: a sum above the maximum writes 2^(DATA_W-1)-1, and a sum below the minimum writes -2^(DATA_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for one update pass |
| mu_i | input | DATA_W | Relaxation factor, signed fixed point |
| eps_i | input | DATA_W | Last normalised error element, signed fixed point |
| ux_base_i | input | UX_AW | Circular excitation store base pointer |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | Pass complete pulse |
| ux0_addr_o | output | UX_AW | Excitation read address, lane 0 |
| ux0_data_i | input | DATA_W | Excitation read data, lane 0 (1-cycle latency) |
| ux1_addr_o | output | UX_AW | Excitation read address, lane 1 |
| ux1_data_i | input | DATA_W | Excitation read data, lane 1 (1-cycle latency) |
| b0_rd_en_o | output | 1 | Bank 0 read enable |
| b0_rd_addr_o | output | BANK_AW | Bank 0 read address |
| b0_rd_data_i | input | DATA_W | Bank 0 read data (1-cycle latency) |
| b0_wr_en_o | output | 1 | Bank 0 write enable |
| b0_wr_addr_o | output | BANK_AW | Bank 0 write address |
| b0_wr_data_o | output | DATA_W | Bank 0 write data |
| b1_rd_en_o | output | 1 | Bank 1 read enable |
| b1_rd_addr_o | output | BANK_AW | Bank 1 read address |
| b1_rd_data_i | input | DATA_W | Bank 1 read data (1-cycle latency) |
| b1_wr_en_o | output | 1 | Bank 1 write enable |
| b1_wr_addr_o | output | BANK_AW | Bank 1 write address |
| b1_wr_data_o | output | DATA_W | Bank 1 write data |

## Verification
Every result has a fixed delay from the edge that samples start_i. The first excitation and bank addresses are valid just after that edge, and the first pair of writes comes two edges later. done_o follows ceil(L/2)+2 edges after the start edge, and both banks hold their final contents one edge after that. The bench counts edges from the start edge and samples 1 ns after each edge, so it compares addresses, write enables, the done edge and the bank contents exactly in those cycles. Bank contents are checked against a model of the update that the bench computes itself.

// File: rtl/coef_upd_pkg.sv
package coef_upd_pkg;
  // per-stage pipeline flags
  typedef struct packed {
    logic vld;   // slot carries an issued element
    logic live;  // element maps to a real coefficient
    logic last;  // final element of the sweep
  } slot_t;
endpackage

// File: rtl/cu_ctrl.sv
module cu_ctrl
  import coef_upd_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int FRAC_W  = 14,
  parameter int UX_AW   = 6,
  parameter int HALF    = 11,
  parameter int BANK_AW = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [DATA_W-1:0]        mu_i,
  input  logic [DATA_W-1:0]        eps_i,
  input  logic [UX_AW-1:0]         ux_base_i,
  input  logic                     fin_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     issue_o,
  output logic                     last_o,
  output logic [BANK_AW-1:0]       idx_o,
  output logic signed [DATA_W-1:0] step_o,
  output logic [UX_AW-1:0]         base_o
);
  localparam int PW = 2 * DATA_W;
  localparam logic signed [PW-1:0] MAXV = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = ~MAXV;

  logic                     busy_q, done_q, iss_q;
  logic [BANK_AW-1:0]       cnt_q;
  logic signed [DATA_W-1:0] step_q, step_nxt;
  logic [UX_AW-1:0]         base_q;
  logic signed [PW-1:0]     raw, shr;

  assign raw = $signed(mu_i) * $signed(eps_i);
  assign shr = raw >>> FRAC_W;

  always_comb begin
    if (shr > MAXV)      step_nxt = MAXV[DATA_W-1:0];
    else if (shr < MINV) step_nxt = MINV[DATA_W-1:0];
    else                 step_nxt = shr[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      iss_q  <= 1'b0;
      cnt_q  <= '0;
      step_q <= '0;
      base_q <= '0;
    end else begin
      done_q <= fin_i;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        iss_q  <= 1'b1;
        cnt_q  <= '0;
        step_q <= step_nxt;
        base_q <= ux_base_i;
      end else begin
        if (iss_q) begin
          if (cnt_q == BANK_AW'(HALF - 1)) iss_q <= 1'b0;
          else                             cnt_q <= cnt_q + 1'b1;
        end
        if (fin_i) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign issue_o = iss_q;
  assign last_o  = (cnt_q == BANK_AW'(HALF - 1));
  assign idx_o   = cnt_q;
  assign step_o  = step_q;
  assign base_o  = base_q;

  AST_STEP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $stable(step_q)); // R2
  AST_BUSY_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_q |=> busy_q); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8
  AST_ISSUE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_q |-> busy_q); // R9
endmodule

// File: rtl/cu_lane.sv
module cu_lane
  import coef_upd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int FRAC_W   = 14,
  parameter int UX_AW    = 6,
  parameter int BANK_AW  = 4,
  parameter int FILT_LEN = 21,
  parameter int PROJ_N   = 4,
  parameter int LANE     = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     issue_i,
  input  logic                     last_i,
  input  logic [BANK_AW-1:0]       idx_i,
  input  logic signed [DATA_W-1:0] step_i,
  input  logic [UX_AW-1:0]         base_i,
  input  logic [DATA_W-1:0]        rd_data_i,
  input  logic [DATA_W-1:0]        ux_data_i,
  output logic                     rd_en_o,
  output logic [BANK_AW-1:0]       rd_addr_o,
  output logic [UX_AW-1:0]         ux_addr_o,
  output logic                     wr_en_o,
  output logic [BANK_AW-1:0]       wr_addr_o,
  output logic [DATA_W-1:0]        wr_data_o,
  output logic                     fin_o
);
  localparam int PW = 2 * DATA_W;
  localparam logic signed [PW:0] MAXV = {{(DATA_W+2){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PW:0] MINV = ~MAXV;

  logic                 live;
  slot_t                s1_q, s2_q;
  logic [BANK_AW-1:0]   s1_idx, s2_idx;
  logic signed [PW-1:0] prod, upd, s2_upd;
  logic [DATA_W-1:0]    s2_w;
  logic signed [PW:0]   sum;

  // issue stage: coefficient index = 2*idx + LANE
  assign live      = (2 * int'(idx_i) + LANE) < FILT_LEN;
  assign rd_en_o   = issue_i && live;
  assign rd_addr_o = idx_i;
  assign ux_addr_o = UX_AW'(int'(base_i) + PROJ_N - 1 + 2 * int'(idx_i) + LANE);

  // stage 1: bank and excitation words arrive
  assign prod = $signed(step_i) * $signed(ux_data_i);
  assign upd  = prod >>> FRAC_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      s1_idx <= '0;
      s2_idx <= '0;
      s2_upd <= '0;
      s2_w   <= '0;
    end else begin
      s1_q   <= '{vld: issue_i, live: issue_i && live, last: issue_i && last_i};
      s1_idx <= idx_i;
      s2_q   <= s1_q;
      s2_idx <= s1_idx;
      if (s1_q.vld) begin
        s2_upd <= upd;
        s2_w   <= rd_data_i;
      end
    end
  end

  // stage 2: add, saturate, write
  assign sum = {{(PW+1-DATA_W){s2_w[DATA_W-1]}}, s2_w} + {s2_upd[PW-1], s2_upd};

  always_comb begin
    if (sum > MAXV)      wr_data_o = MAXV[DATA_W-1:0];
    else if (sum < MINV) wr_data_o = MINV[DATA_W-1:0];
    else                 wr_data_o = sum[DATA_W-1:0];
  end

  assign wr_en_o   = s2_q.vld && s2_q.live;
  assign wr_addr_o = s2_idx;
  assign fin_o     = s2_q.vld && s2_q.last;

  AST_RD_TO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(rd_en_o, 2)); // R7
  AST_WR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && $past(wr_en_o) |-> wr_addr_o == $past(wr_addr_o) + 1'b1); // R7
  AST_WR_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (2 * int'(wr_addr_o) + LANE) < FILT_LEN); // R6
endmodule

// File: rtl/coef_dual_updater.sv
module coef_dual_updater
  import coef_upd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int FRAC_W   = 14,
  parameter int FILT_LEN = 21,
  parameter int PROJ_N   = 4,
  parameter int UX_AW    = 6,
  localparam int HALF    = (FILT_LEN + 1) / 2,
  localparam int BANK_AW = $clog2(HALF)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DATA_W-1:0]  mu_i,
  input  logic [DATA_W-1:0]  eps_i,
  input  logic [UX_AW-1:0]   ux_base_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [UX_AW-1:0]   ux0_addr_o,
  input  logic [DATA_W-1:0]  ux0_data_i,
  output logic [UX_AW-1:0]   ux1_addr_o,
  input  logic [DATA_W-1:0]  ux1_data_i,
  output logic               b0_rd_en_o,
  output logic [BANK_AW-1:0] b0_rd_addr_o,
  input  logic [DATA_W-1:0]  b0_rd_data_i,
  output logic               b0_wr_en_o,
  output logic [BANK_AW-1:0] b0_wr_addr_o,
  output logic [DATA_W-1:0]  b0_wr_data_o,
  output logic               b1_rd_en_o,
  output logic [BANK_AW-1:0] b1_rd_addr_o,
  input  logic [DATA_W-1:0]  b1_rd_data_i,
  output logic               b1_wr_en_o,
  output logic [BANK_AW-1:0] b1_wr_addr_o,
  output logic [DATA_W-1:0]  b1_wr_data_o
);
  logic                     issue, last;
  logic [BANK_AW-1:0]       idx;
  logic signed [DATA_W-1:0] step;
  logic [UX_AW-1:0]         base;
  logic [1:0]               fin, rd_en, wr_en;
  logic [BANK_AW-1:0]       rd_addr [2];
  logic [BANK_AW-1:0]       wr_addr [2];
  logic [UX_AW-1:0]         ux_addr [2];
  logic [DATA_W-1:0]        rd_data [2];
  logic [DATA_W-1:0]        ux_data [2];
  logic [DATA_W-1:0]        wr_data [2];

  cu_ctrl #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .UX_AW(UX_AW), .HALF(HALF), .BANK_AW(BANK_AW)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .mu_i, .eps_i, .ux_base_i,
    .fin_i(&fin), .busy_o, .done_o,
    .issue_o(issue), .last_o(last), .idx_o(idx), .step_o(step), .base_o(base)
  );

  assign rd_data[0] = b0_rd_data_i;
  assign rd_data[1] = b1_rd_data_i;
  assign ux_data[0] = ux0_data_i;
  assign ux_data[1] = ux1_data_i;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    cu_lane #(
      .DATA_W(DATA_W), .FRAC_W(FRAC_W), .UX_AW(UX_AW), .BANK_AW(BANK_AW),
      .FILT_LEN(FILT_LEN), .PROJ_N(PROJ_N), .LANE(g)
    ) u_lane (
      .clk_i, .rst_ni,
      .issue_i(issue), .last_i(last), .idx_i(idx), .step_i(step), .base_i(base),
      .rd_data_i(rd_data[g]), .ux_data_i(ux_data[g]),
      .rd_en_o(rd_en[g]), .rd_addr_o(rd_addr[g]), .ux_addr_o(ux_addr[g]),
      .wr_en_o(wr_en[g]), .wr_addr_o(wr_addr[g]), .wr_data_o(wr_data[g]),
      .fin_o(fin[g])
    );
  end

  assign ux0_addr_o   = ux_addr[0];
  assign ux1_addr_o   = ux_addr[1];
  assign b0_rd_en_o   = rd_en[0];
  assign b0_rd_addr_o = rd_addr[0];
  assign b0_wr_en_o   = wr_en[0];
  assign b0_wr_addr_o = wr_addr[0];
  assign b0_wr_data_o = wr_data[0];
  assign b1_rd_en_o   = rd_en[1];
  assign b1_rd_addr_o = rd_addr[1];
  assign b1_wr_en_o   = wr_en[1];
  assign b1_wr_addr_o = wr_addr[1];
  assign b1_wr_data_o = wr_data[1];

  AST_BANKS_LOCKSTEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b1_wr_en_o |-> b0_wr_en_o && (b0_wr_addr_o == b1_wr_addr_o)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !b0_rd_en_o && !b1_rd_en_o); // R1
endmodule

// File: tb/sim_coef_dual_updater.sv
module sim_coef_dual_updater;
  localparam int DW = 16, FW = 14, L = 21, N = 4, AW = 6;
  localparam int HALF = (L + 1) / 2, BW = $clog2(HALF), UXD = 1 << AW;
  localparam int SENT = 4660;
  // table: {mu, eps, base} each 16 bits
  localparam logic [47:0] VEC [0:3] = '{
    {16'd16384, 16'd3000,  16'd0},
    {16'd8192,  -16'sd12000, 16'd62},
    {16'd24576, 16'd7777,  16'd17},
    {16'd4096,  -16'sd500, 16'd40}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [DW-1:0] mu = '0, eps = '0;
  logic [AW-1:0] base = '0;
  logic busy, done;
  logic [AW-1:0] ux0_a, ux1_a;
  logic [DW-1:0] ux0_d, ux1_d, b0_rd, b1_rd, b0_wd, b1_wd;
  logic b0_re, b1_re, b0_we, b1_we;
  logic [BW-1:0] b0_ra, b1_ra, b0_wa, b1_wa;

  logic [DW-1:0] m0 [HALF];
  logic [DW-1:0] m1 [HALF];
  logic [DW-1:0] mux [UXD];
  logic ld_en = 1'b0;
  int ld_idx = 0;
  logic [DW-1:0] ld0 = '0, ld1 = '0, ldu = '0;

  int sw0 [HALF], sw1 [HALF], ew0 [HALF], ew1 [HALF], sux [UXD];
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  coef_dual_updater #(.DATA_W(DW), .FRAC_W(FW), .FILT_LEN(L), .PROJ_N(N), .UX_AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mu_i(mu), .eps_i(eps), .ux_base_i(base),
    .busy_o(busy), .done_o(done),
    .ux0_addr_o(ux0_a), .ux0_data_i(ux0_d), .ux1_addr_o(ux1_a), .ux1_data_i(ux1_d),
    .b0_rd_en_o(b0_re), .b0_rd_addr_o(b0_ra), .b0_rd_data_i(b0_rd),
    .b0_wr_en_o(b0_we), .b0_wr_addr_o(b0_wa), .b0_wr_data_o(b0_wd),
    .b1_rd_en_o(b1_re), .b1_rd_addr_o(b1_ra), .b1_rd_data_i(b1_rd),
    .b1_wr_en_o(b1_we), .b1_wr_addr_o(b1_wa), .b1_wr_data_o(b1_wd)
  );

  // memory models, 1-cycle read latency
  always @(posedge clk) begin
    if (ld_en) begin
      mux[ld_idx] <= ldu;
      if (ld_idx < HALF) begin
        m0[ld_idx] <= ld0;
        m1[ld_idx] <= ld1;
      end
    end
    if (b0_we) m0[b0_wa] <= b0_wd;
    if (b1_we) m1[b1_wa] <= b1_wd;
    if (b0_re) b0_rd <= m0[b0_ra];
    if (b1_re) b1_rd <= m1[b1_ra];
    ux0_d <= mux[ux0_a];
    ux1_d <= mux[ux1_a];
  end

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_all();
    for (int i = 0; i < UXD; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_idx = i; ldu = sux[i][DW-1:0];
      if (i < HALF) begin ld0 = sw0[i][DW-1:0]; ld1 = sw1[i][DW-1:0]; end
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic compute_exp(int m, int e, int b);
    int step;
    step = sat16((longint'(m) * e) >>> FW);
    for (int i = 0; i < L; i++) begin
      int w, u, nw;
      w  = (i % 2 == 0) ? sw0[i/2] : sw1[i/2];
      u  = sux[(b + N - 1 + i) % UXD];
      nw = sat16(longint'(w) + ((longint'(step) * u) >>> FW));
      if (i % 2 == 0) ew0[i/2] = nw; else ew1[i/2] = nw;
    end
    ew1[HALF-1] = sw1[HALF-1];
  endtask

  task automatic run_update(int m, int e, int b, bit inject);
    int k;
    @(negedge clk);
    mu = m[DW-1:0]; eps = e[DW-1:0]; base = b[AW-1:0]; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    k = 0;
    chk(busy === 1'b1, "R8 busy after start", int'(busy), 1);
    chk(ux0_a == AW'((b + N - 1) % UXD) && ux1_a == AW'((b + N) % UXD),
        "R5 first excitation addresses", int'(ux0_a), (b + N - 1) % UXD);
    chk(b0_re && b1_re && b0_ra == 0 && b1_ra == 0, "R7 concurrent first reads",
        int'({b0_re, b1_re}), 3);
    while (!done && k < 200) begin
      if (inject && k == 3) begin start = 1'b1; mu = mu + 16'd100; end
      else start = 1'b0;
      @(posedge clk); #1;
      k++;
      if (k == 2) chk(b0_we && b1_we && b0_wa == 0 && b1_wa == 0,
                      "R7 first writes two edges after start", int'({b0_we, b1_we}), 3);
    end
    start = 1'b0;
    chk(k == HALF + 2, "R8 done latency", k, HALF + 2);
    chk(busy == 1'b0, "R8 busy falls with done", int'(busy), 0);
    @(posedge clk); #1;
    chk(done == 1'b0, "R8 done single cycle", int'(done), 0);
    repeat (4) @(posedge clk);
    #1;
    chk(busy == 1'b0 && done == 1'b0, "R9 no second pass", int'(busy), 0);
  endtask

  task automatic compare(string tag);
    int bad0, bad1, a0, e0, a1, e1;
    bad0 = -1; bad1 = -1; a0 = 0; e0 = 0; a1 = 0; e1 = 0;
    for (int i = 0; i < HALF; i++) begin
      if (bad0 < 0 && int'($signed(m0[i])) != ew0[i]) begin
        bad0 = i; a0 = int'($signed(m0[i])); e0 = ew0[i];
      end
      if (bad1 < 0 && int'($signed(m1[i])) != ew1[i]) begin
        bad1 = i; a1 = int'($signed(m1[i])); e1 = ew1[i];
      end
    end
    chk(bad0 < 0, {tag, " R3 R4 bank0 even coefficients"}, a0, e0);
    chk(bad1 < 0, {tag, " R3 R4 R5 bank1 odd coefficients"}, a1, e1);
    chk(int'($signed(m1[HALF-1])) == SENT, {tag, " R6 unused bank1 slot"},
        int'($signed(m1[HALF-1])), SENT);
    for (int i = 0; i < HALF; i++) begin sw0[i] = ew0[i]; sw1[i] = ew1[i]; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !done && !b0_re && !b1_re && !b0_we && !b1_we, "R1 reset state",
        int'({busy, done, b0_re, b1_re, b0_we, b1_we}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!busy && !done && !b0_we && !b1_we, "R1 after reset release", int'(busy), 0);

    for (int i = 0; i < UXD; i++) sux[i] = int'($urandom_range(16000)) - 8000;
    for (int i = 0; i < HALF; i++) begin
      sw0[i] = int'($urandom_range(16000)) - 8000;
      sw1[i] = int'($urandom_range(16000)) - 8000;
    end
    sw1[HALF-1] = SENT;
    load_all();

    // vector table
    for (int v = 0; v < 4; v++) begin
      int m, e, b;
      m = int'($signed(VEC[v][47:32]));
      e = int'($signed(VEC[v][31:16]));
      b = int'(VEC[v][15:0]);
      compute_exp(m, e, b);
      run_update(m, e, b, 1'b0);
      compare("table");
    end

    // start while busy, operands changed mid-pass (R9, R2)
    compute_exp(12000, -9000, 61);
    run_update(12000, -9000, 61, 1'b1);
    compare("R9 R2 ignored start");

    // saturation at both rails (R10)
    for (int i = 0; i < UXD; i++) sux[i] = (i % 2 == 1) ? 30000 : -30000;
    for (int i = 0; i < HALF; i++) begin sw0[i] = 30000; sw1[i] = -30000; end
    sw1[HALF-1] = SENT;
    load_all();
    compute_exp(32767, 32767, 0);
    run_update(32767, 32767, 0, 1'b0);
    chk(int'($signed(m0[0])) == 32767, "R10 positive rail", int'($signed(m0[0])), 32767);
    chk(int'($signed(m1[0])) == -32768, "R10 negative rail", int'($signed(m1[0])), -32768);
    compare("R10 saturation");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule